// File: doc/BRIEF.md
# Write-Once System Options Register

This block is a byte-wide configuration register for chip-level options. It sits on a simple peripheral bus that has one address decode and a one-cycle write strobe. It takes exactly one write after each reset. Every later write is dropped until the next reset arrives. The register can be read back at any time.

The register holds five settings:
- a two-bit watchdog timeout select, exported unchanged so that an external watchdog can combine it with its clock-source choice;
- a stop-mode enable;
- a two-wire serial bus pin-location select;
- a debug-pin enable;
- a reset-pin enable, which also turns on the internal pull-up of that pin.

The block watches a stop-instruction strobe from the core. If stop mode is enabled, the block raises a one-cycle stop-entry pulse. If it is not enabled, the block raises a one-cycle illegal-opcode reset request instead.

Reset behaviour depends on the reset type. Every reset restores the timeout select, the stop enable, the pin-location select, the debug-pin enable and the write lock. The reset-pin enable is cleared only by power-on reset; it keeps its value through low-voltage and other internal resets. The bus has no back-pressure: a write strobe that hits the register address is always taken in its own cycle, either stored or dropped. The stop strobe is a plain control pulse with no handshake.

Top module: `sysopt_reg`

## Requirements
- R1: The first write strobe whose address matches, after any reset, loads the register. The new value is visible on `rd_data` and on the field outputs in the cycle that follows the write edge.
- R2: After that first write, every further write is ignored until the next reset. This holds even when the first write carried exactly the reset value.
- R3: Register bits 4:3 are reserved. They always read 0, and any value written to them is discarded.
- R4: Every reset type leaves the following: bits 7:6 (timeout select) = 2'b11, bit 5 (stop enable) = 0, bit 2 (pin-location select) = 0, bit 1 (debug-pin enable) = 1, and the write lock cleared.
- R5: Bit 0 (reset-pin enable) is cleared to 0 by a reset with `rst_por` high. A reset with `rst_por` low leaves it unchanged.
- R6: A stop strobe seen while bit 5 is 0 gives `illegal_rst_req` high for exactly the next cycle, with `stop_enter` low.
- R7: A stop strobe seen while bit 5 is 1 gives `stop_enter` high for exactly the next cycle, with `illegal_rst_req` low.
- R8: `i2c_loc_b` follows bit 2 (0 = location A, 1 = location B). `dbg_pin_en` follows bit 1 (1 = debug/mode pin, 0 = general output or comparator output).
- R9: `rst_pin_en` and `rst_pullup_en` both follow bit 0.
- R10: `wdog_tsel` always equals bits 7:6.
- R11: A write strobe with a non-matching address changes nothing and does not set the write lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, any reset type |
| rst_por | input | 1 | High while `rst_n` is low marks a power-on reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Register contents, readable at any time |
| stop_req | input | 1 | Stop-instruction strobe from the core |
| stop_enter | output | 1 | One-cycle stop-mode entry pulse |
| illegal_rst_req | output | 1 | One-cycle illegal-opcode reset request |
| wdog_tsel | output | 2 | Watchdog timeout select |
| i2c_loc_b | output | 1 | Serial bus pin-location select |
| dbg_pin_en | output | 1 | Shared pin acts as debug/mode pin |
| rst_pin_en | output | 1 | Shared pin acts as reset input |
| rst_pullup_en | output | 1 | Internal pull-up enable for the reset pin |

## Verification
A write strobe is sampled on one rising edge, and its result appears on `rd_data` and the field outputs in the cycle after that edge. Each write check therefore samples at the falling edge that follows the capturing edge. A stop strobe is registered once, so its pulse is checked at the next falling edge, and the pulse is checked to be gone one cycle later. Reset values are sampled at the first falling edge after `rst_n` rises. Inputs are driven on falling edges, so no check depends on the order of processes at a clock edge.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  // Field positions
  localparam int TSEL_LO   = 6;
  localparam int TSEL_W    = 2;
  localparam int STOPEN_B  = 5;
  localparam int I2CLOC_B  = 2;
  localparam int DBGEN_B   = 1;
  localparam int RSTEN_B   = 0;

  // Implemented bits: 7:5 and 2:0
  localparam logic [DATA_W-1:0] WR_MASK   = 8'b1110_0111;
  // Bits that survive a non power-on reset
  localparam logic [DATA_W-1:0] KEEP_MASK = 8'b0000_0001;
  // Value after any reset, before the kept bits are merged in
  localparam logic [DATA_W-1:0] RST_BASE  = 8'b1100_0010;
endpackage

// File: rtl/sysopt_bus_dec.sv
module sysopt_bus_dec
  import sysopt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] cfg_q,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    wr_hit  = bus_wr && (bus_addr == REG_ADDR);
    rd_data = cfg_q & WR_MASK;
  end
endmodule

// File: rtl/sysopt_store.sv
module sysopt_store
  import sysopt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_por,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);
  logic locked_q;
  logic past_valid;

  always_ff @(posedge clk) begin
    past_valid <= 1'b1;
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= (RST_BASE & ~KEEP_MASK) |
                  (rst_por ? '0 : (cfg_q & KEEP_MASK));
    end else if (wr_hit && !locked_q) begin
      locked_q <= 1'b1;
      cfg_q    <= wdata & WR_MASK;
    end
  end

  assert_lock_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !locked_q) |=> (locked_q && cfg_q == ($past(wdata) & WR_MASK)));

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));

  assert_nonpor_keep_R5: assert property (@(posedge clk) disable iff (!past_valid)
    (!rst_n && !rst_por) |=> (cfg_q[RSTEN_B] == $past(cfg_q[RSTEN_B])));

  assert_por_clear_R5: assert property (@(posedge clk) disable iff (!past_valid)
    (!rst_n && rst_por) |=> !cfg_q[RSTEN_B]);
endmodule

// File: rtl/sysopt_stop_ctl.sv
module sysopt_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_en,
  output logic stop_enter,
  output logic illegal_rst_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_enter      <= 1'b0;
      illegal_rst_req <= 1'b0;
    end else begin
      stop_enter      <= stop_req && stop_en;
      illegal_rst_req <= stop_req && !stop_en;
    end
  end

  assert_illegal_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_en) |=> (illegal_rst_req && !stop_enter));

  assert_stop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && stop_en) |=> (stop_enter && !illegal_rst_req));

  assert_quiet_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |=> (!stop_enter && !illegal_rst_req));
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_por,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_req,
  output logic              stop_enter,
  output logic              illegal_rst_req,
  output logic [TSEL_W-1:0] wdog_tsel,
  output logic              i2c_loc_b,
  output logic              dbg_pin_en,
  output logic              rst_pin_en,
  output logic              rst_pullup_en
);
  logic              wr_hit;
  logic [DATA_W-1:0] cfg_q;

  sysopt_bus_dec #(.REG_ADDR(REG_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .cfg_q    (cfg_q),
    .wr_hit   (wr_hit),
    .rd_data  (rd_data)
  );

  sysopt_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_por (rst_por),
    .wr_hit  (wr_hit),
    .wdata   (bus_wdata),
    .cfg_q   (cfg_q)
  );

  sysopt_stop_ctl u_stop (
    .clk             (clk),
    .rst_n           (rst_n),
    .stop_req        (stop_req),
    .stop_en         (cfg_q[STOPEN_B]),
    .stop_enter      (stop_enter),
    .illegal_rst_req (illegal_rst_req)
  );

  always_comb begin
    wdog_tsel     = cfg_q[TSEL_LO +: TSEL_W];
    i2c_loc_b     = cfg_q[I2CLOC_B];
    dbg_pin_en    = cfg_q[DBGEN_B];
    rst_pin_en    = cfg_q[RSTEN_B];
    rst_pullup_en = cfg_q[RSTEN_B];
  end

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:3] == 2'b00);

  assert_miss_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_ADDR) |=> $stable(rd_data));

  assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_enter && illegal_rst_req));
endmodule

// File: tb/sim_sysopt_reg.sv
`timescale 1ns/1ps
module sim_sysopt_reg;
  localparam logic [7:0] ADDR = 8'h1A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, rst_por = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, stop_req = 1'b0;
  logic [7:0] rd_data;
  logic       stop_enter, illegal_rst_req, i2c_loc_b, dbg_pin_en, rst_pin_en, rst_pullup_en;
  logic [1:0] wdog_tsel;
  int n_tests = 0, n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sysopt_reg #(.REG_ADDR(ADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_por(rst_por),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .stop_req(stop_req), .stop_enter(stop_enter),
    .illegal_rst_req(illegal_rst_req), .wdog_tsel(wdog_tsel),
    .i2c_loc_b(i2c_loc_b), .dbg_pin_en(dbg_pin_en),
    .rst_pin_en(rst_pin_en), .rst_pullup_en(rst_pullup_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Full check of the register and all field outputs
  task automatic check_cfg(input string req, input logic [7:0] v);
    check(req, rd_data, v);
    check({req, "/R10 tsel"}, {6'b0, wdog_tsel}, {6'b0, v[7:6]});
    check({req, "/R8 i2c"}, {7'b0, i2c_loc_b}, {7'b0, v[2]});
    check({req, "/R8 dbg"}, {7'b0, dbg_pin_en}, {7'b0, v[1]});
    check({req, "/R9 rstpin"}, {6'b0, rst_pin_en, rst_pullup_en}, {6'b0, v[0], v[0]});
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    rst_n = 1'b0; rst_por = por;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; rst_por = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic stop_pulse(input logic exp_enter);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(exp_enter ? "R7 enter" : "R6 enter", {7'b0, stop_enter}, {7'b0, exp_enter});
    check(exp_enter ? "R7 illegal" : "R6 illegal", {7'b0, illegal_rst_req}, {7'b0, !exp_enter});
    @(negedge clk);
    check("R6/R7 pulse ends", {6'b0, stop_enter, illegal_rst_req}, 8'h00);
  endtask

  task automatic t_por_reset;
    do_reset(1'b1);
    check_cfg("R4 R5 por reset", 8'hC2);
    check("R6 idle", {6'b0, stop_enter, illegal_rst_req}, 8'h00);
  endtask

  task automatic t_first_write;
    bus_write(ADDR, 8'h3F);
    check_cfg("R1 R3 first write", 8'h27);
  endtask

  task automatic t_second_write;
    bus_write(ADDR, 8'h00);
    check_cfg("R2 later write", 8'h27);
  endtask

  task automatic t_nonpor_reset;
    do_reset(1'b0);
    check_cfg("R4 R5 internal reset keeps rst pin", 8'hC3);
  endtask

  task automatic t_miss_then_same_value;
    bus_write(8'h1B, 8'h00);
    check_cfg("R11 address miss", 8'hC3);
    bus_write(ADDR, 8'hC3);
    check_cfg("R1 same value", 8'hC3);
    bus_write(ADDR, 8'h24);
    check_cfg("R2 lock after equal value", 8'hC3);
  endtask

  task automatic t_por_then_write;
    do_reset(1'b1);
    check_cfg("R5 por clears", 8'hC2);
    bus_write(ADDR, 8'h98);
    check_cfg("R1 R3 R10 write", 8'h80);
  endtask

  initial begin
    do_reset(1'b1);
    t_por_reset();
    stop_pulse(1'b0);          // R6: stop enable is 0
    t_first_write();
    t_second_write();
    stop_pulse(1'b1);          // R7: stop enable is 1
    t_nonpor_reset();
    stop_pulse(1'b0);          // R6 after reset
    t_miss_then_same_value();
    t_por_then_write();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule